// File: doc/BRIEF.md
# Windowed Deadman Timer

This supervisory timer counts system clocks while its enable bit is set. Software keeps it alive with a two-step service. It first writes an arming key to the pre-clear register. It then writes a clear key to the clear register, and that second write must fall inside a service window that sits just below the terminal count. A correct service returns the counter to zero. A wrong key, a clear key out of order or out of the window, or the counter reaching its terminal count latches an event flag and raises a reset request that a chip-level reset generator acts on.

The block sits on a simple register bus. It has an address, write data, a write strobe and a combinational read path. Status flags record the event and which of the two key steps went wrong. A reset-cause flag records that a deadman event took place. That flag has its own power-on reset, so it survives the system reset that the request triggers, and software clears it by writing a one to it. The enable bit can be written directly, or changed through set and clear alias addresses, so software never needs a read-modify-write.

Top module: `deadman_wdt`

## Requirements
- R1: After `rst_n` and `por_n` are released, the block is disabled and the counter reads 0. The status and reset-cause registers read 0 and `rst_req` is low. The terminal-count register (0x60) reads `TERM_RST` and the window register (0x70) reads `WIN_RST`.
- R2: Bit 15 of the control word is the enable. A write to 0x00 loads it. A write to 0x08 sets it where wdata[15]=1, and a write to 0x04 clears it where wdata[15]=1. Reading 0x00 returns the enable in bit 15.
- R3: The enabling write (0 to 1) sets the counter to 0. The counter then rises by one on every clock while enabled, below terminal count and with no event. While disabled it holds its value. Reading 0x40 returns the counter.
- R4: Status bit 0 (register 0x30) is 1 exactly while enabled, with no event, and the counter lies in [T-W, T). T is terminal count and W is the window length; T-W saturates at 0 when W >= T.
- R5: A write of 0x4000 to 0x10 (key 0x40 in bits 15:8), followed later by a write of 0x08 in bits 7:0 to 0x20 while the window is open, sets the counter to 0 on that edge. It sets no flag.
- R6: A write to 0x10 while enabled whose bits 15:8 differ from 0x40 sets status bit 7 and bit 5, and raises `rst_req`.
- R7: A write to 0x20 while enabled that is not a valid service sets status bit 6 and bit 5, and raises `rst_req`. Invalid means no armed pre-clear, the window closed, or bits 7:0 not 0x08.
- R8: When the counter equals terminal count, status bit 5 and `rst_req` rise on the next edge. The counter then stays at terminal count.
- R9: In the cycle right after a write clears the enable, every write is ignored and `rdata` reads 0.
- R10: Bit 5 of register 0x80 is set by any deadman event. It survives `rst_n` and is cleared only by `por_n` or by writing 1 to that bit.
- R11: The enabling write clears status bits 5 to 7 and drops `rst_req`.
- R12: Writes to 0x10 and 0x20 while disabled have no effect on status, `rst_req` or the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that the timer counts |
| rst_n | input | 1 | Active-low system reset for the timer state |
| por_n | input | 1 | Active-low power-on reset for the reset-cause flag only |
| addr | input | ADDR_W | Register byte address |
| wdata | input | DATA_W | Write data |
| we | input | 1 | Write strobe, one write per cycle |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| rst_req | output | 1 | Reset request, high while the event flag is set |

## Verification
The bench builds the block with a 16-bit counter, a default terminal count of 40 and a default window of 8. It then reprograms terminal counts between 10 and 50. At these sizes the timeout edge, the first and last open-window counts, and a clear key written exactly at terminal count all occur within a few dozen cycles. Random window lengths that reach or exceed the terminal count exercise the saturating window start, where the window opens from count zero.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  // register byte offsets
  localparam logic [7:0] OFS_CTRL     = 8'h00;
  localparam logic [7:0] OFS_CTRL_CLR = 8'h04;
  localparam logic [7:0] OFS_CTRL_SET = 8'h08;
  localparam logic [7:0] OFS_PRE      = 8'h10;
  localparam logic [7:0] OFS_CLR      = 8'h20;
  localparam logic [7:0] OFS_STAT     = 8'h30;
  localparam logic [7:0] OFS_CNT      = 8'h40;
  localparam logic [7:0] OFS_TERM     = 8'h60;
  localparam logic [7:0] OFS_WIN      = 8'h70;
  localparam logic [7:0] OFS_CAUSE    = 8'h80;

  // field positions
  localparam int EN_BIT      = 15;
  localparam int PRE_KEY_LSB = 8;
  localparam int ST_WIN      = 0;
  localparam int ST_EVT      = 5;
  localparam int ST_BAD2     = 6;
  localparam int ST_BAD1     = 7;
  localparam int CAUSE_BIT   = 5;

  // key values
  localparam logic [7:0] ARM_KEY   = 8'h40;
  localparam logic [7:0] CLEAR_KEY = 8'h08;

  function automatic logic arm_key_ok(input logic [7:0] b);
    return b == ARM_KEY;
  endfunction

  function automatic logic clear_key_ok(input logic [7:0] b);
    return b == CLEAR_KEY;
  endfunction

endpackage

// File: rtl/dmt_regs.sv
module dmt_regs
  import dmt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int TERM_RST = 1000000,
  parameter int WIN_RST  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic              en,
  output logic              quiet,
  output logic              en_start,
  output logic              pre_wr,
  output logic              clr_wr,
  output logic              cause_w1c,
  output logic [CNT_W-1:0]  term,
  output logic [CNT_W-1:0]  win
);

  logic acc;
  logic en_next;
  logic en_stop;

  // a write is taken unless the bus is in its dead cycle after a stop
  assign acc = we && !quiet;

  always_comb begin
    en_next = en;
    if (acc) begin
      if (addr == ADDR_W'(OFS_CTRL))
        en_next = wdata[EN_BIT];
      else if (addr == ADDR_W'(OFS_CTRL_SET))
        en_next = en | wdata[EN_BIT];
      else if (addr == ADDR_W'(OFS_CTRL_CLR))
        en_next = en & ~wdata[EN_BIT];
    end
  end

  assign en_start  = !en && en_next;
  assign en_stop   = en && !en_next;
  assign pre_wr    = acc && en && (addr == ADDR_W'(OFS_PRE));
  assign clr_wr    = acc && en && (addr == ADDR_W'(OFS_CLR));
  assign cause_w1c = acc && (addr == ADDR_W'(OFS_CAUSE)) && wdata[CAUSE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      quiet <= 1'b0;
      term  <= CNT_W'(TERM_RST);
      win   <= CNT_W'(WIN_RST);
    end else begin
      en    <= en_next;
      quiet <= en_stop;
      if (acc && addr == ADDR_W'(OFS_TERM)) term <= wdata[CNT_W-1:0];
      if (acc && addr == ADDR_W'(OFS_WIN))  win  <= wdata[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/dmt_keys.sv
module dmt_keys
  import dmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_start,
  input  logic       pre_wr,
  input  logic       clr_wr,
  input  logic [7:0] pre_byte,
  input  logic [7:0] clr_byte,
  input  logic       win_open,
  output logic       armed,
  output logic       svc_ok,
  output logic       set_bad1,
  output logic       set_bad2
);

  logic pre_good;

  assign pre_good = arm_key_ok(pre_byte);
  assign set_bad1 = pre_wr && !pre_good;
  assign svc_ok   = clr_wr && armed && win_open && clear_key_ok(clr_byte);
  assign set_bad2 = clr_wr && !svc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      armed <= 1'b0;
    else if (en_start || clr_wr)
      armed <= 1'b0;
    else if (pre_wr)
      armed <= pre_good;
  end

endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             en_start,
  input  logic             svc_ok,
  input  logic             evt,
  input  logic [CNT_W-1:0] term,
  input  logic [CNT_W-1:0] win,
  output logic [CNT_W-1:0] cnt,
  output logic             win_open,
  output logic             tmo_hit
);

  // first count value at which servicing is allowed
  function automatic logic [CNT_W-1:0] open_point(input logic [CNT_W-1:0] t,
                                                  input logic [CNT_W-1:0] w);
    return (w >= t) ? '0 : t - w;
  endfunction

  logic running;
  logic [CNT_W-1:0] open_at;

  assign running  = en && !evt;
  assign open_at  = open_point(term, win);
  assign tmo_hit  = running && (cnt >= term);
  assign win_open = running && (cnt >= open_at) && (cnt < term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (en_start || svc_ok)
      cnt <= '0;
    else if (running && cnt < term)
      cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/dmt_status.sv
module dmt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic en_start,
  input  logic set_bad1,
  input  logic set_bad2,
  input  logic tmo_hit,
  output logic bad1,
  output logic bad2,
  output logic evt,
  output logic evt_rise
);

  logic any_fault;

  assign any_fault = set_bad1 || set_bad2 || tmo_hit;
  assign evt_rise  = !evt && any_fault && !en_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad1 <= 1'b0;
      bad2 <= 1'b0;
      evt  <= 1'b0;
    end else if (en_start) begin
      bad1 <= 1'b0;
      bad2 <= 1'b0;
      evt  <= 1'b0;
    end else begin
      bad1 <= bad1 | set_bad1;
      bad2 <= bad2 | set_bad2;
      evt  <= evt  | any_fault;
    end
  end

endmodule

// File: rtl/deadman_wdt.sv
module deadman_wdt
  import dmt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int TERM_RST = 1000000,
  parameter int WIN_RST  = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req
);

  logic             en, quiet, en_start, pre_wr, clr_wr, cause_w1c;
  logic [CNT_W-1:0] term, win, cnt;
  logic             win_open, tmo_hit, armed, svc_ok, set_bad1, set_bad2;
  logic             bad1, bad2, evt, evt_rise;
  logic             cause;

  dmt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .TERM_RST(TERM_RST), .WIN_RST(WIN_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
    .en(en), .quiet(quiet), .en_start(en_start), .pre_wr(pre_wr),
    .clr_wr(clr_wr), .cause_w1c(cause_w1c), .term(term), .win(win)
  );

  dmt_keys u_keys (
    .clk(clk), .rst_n(rst_n), .en_start(en_start),
    .pre_wr(pre_wr), .clr_wr(clr_wr),
    .pre_byte(wdata[PRE_KEY_LSB +: 8]), .clr_byte(wdata[7:0]),
    .win_open(win_open), .armed(armed), .svc_ok(svc_ok),
    .set_bad1(set_bad1), .set_bad2(set_bad2)
  );

  dmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .en_start(en_start),
    .svc_ok(svc_ok), .evt(evt), .term(term), .win(win),
    .cnt(cnt), .win_open(win_open), .tmo_hit(tmo_hit)
  );

  dmt_status u_stat (
    .clk(clk), .rst_n(rst_n), .en_start(en_start),
    .set_bad1(set_bad1), .set_bad2(set_bad2), .tmo_hit(tmo_hit),
    .bad1(bad1), .bad2(bad2), .evt(evt), .evt_rise(evt_rise)
  );

  // reset-cause flag lives on the power-on reset only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)
      cause <= 1'b0;
    else if (evt_rise)
      cause <= 1'b1;
    else if (cause_w1c)
      cause <= 1'b0;
  end

  assign rst_req = evt;

  always_comb begin
    rdata = '0;
    if (!quiet) begin
      if (addr == ADDR_W'(OFS_CTRL)) begin
        rdata[EN_BIT] = en;
      end else if (addr == ADDR_W'(OFS_STAT)) begin
        rdata[ST_WIN]  = win_open;
        rdata[ST_EVT]  = evt;
        rdata[ST_BAD2] = bad2;
        rdata[ST_BAD1] = bad1;
      end else if (addr == ADDR_W'(OFS_CNT)) begin
        rdata[CNT_W-1:0] = cnt;
      end else if (addr == ADDR_W'(OFS_TERM)) begin
        rdata[CNT_W-1:0] = term;
      end else if (addr == ADDR_W'(OFS_WIN)) begin
        rdata[CNT_W-1:0] = win;
      end else if (addr == ADDR_W'(OFS_CAUSE)) begin
        rdata[CAUSE_BIT] = cause;
      end
    end
  end

endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              quiet,
  input logic              en_start,
  input logic              svc_ok,
  input logic              set_bad1,
  input logic              tmo_hit,
  input logic              evt,
  input logic              cause,
  input logic              rst_req,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  term,
  input logic [DATA_W-1:0] rdata
);

  // R9
  quiet_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> rdata == '0);

  // R9
  quiet_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> !quiet);

  // R9
  stop_makes_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> quiet);

  // R5
  service_zeroes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ok |=> cnt == '0);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !evt && !en_start && !svc_ok && cnt < term) |=> cnt == $past(cnt) + CNT_W'(1));

  // R8
  timeout_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> rst_req && cnt == $past(cnt));

  // R6
  bad_arm_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_bad1 |=> rst_req);

  // R10
  cause_follows_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> cause);

  // R11
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_start |=> !rst_req && cnt == '0);

  // R8
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !en_start) |=> rst_req);

endmodule

bind deadman_wdt dmt_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .quiet(quiet), .en_start(en_start),
  .svc_ok(svc_ok), .set_bad1(set_bad1), .tmo_hit(tmo_hit), .evt(evt),
  .cause(cause), .rst_req(rst_req), .cnt(cnt), .term(term), .rdata(rdata)
);

// File: tb/tb_deadman_wdt.sv
`timescale 1ns/100ps
module tb_deadman_wdt;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int T0     = 40;
  localparam int W0     = 8;

  localparam logic [7:0] A_CTRL = 8'h00, A_CCLR = 8'h04, A_CSET = 8'h08;
  localparam logic [7:0] A_PRE = 8'h10, A_CLR = 8'h20, A_STAT = 8'h30;
  localparam logic [7:0] A_CNT = 8'h40, A_TERM = 8'h60, A_WIN = 8'h70, A_CAUSE = 8'h80;

  logic              clk = 1'b0;
  logic              rst_n, por_n, we;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              rst_req;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  deadman_wdt #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .TERM_RST(T0), .WIN_RST(W0)
  ) dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .addr(addr),
    .wdata(wdata), .we(we), .rdata(rdata), .rst_req(rst_req)
  );

  // window start as the requirements define it
  function automatic int win_from(input int t, input int w);
    return (w >= t) ? 0 : t - w;
  endfunction

  // clear issued while the counter holds c is a valid service
  function automatic bit svc_expected(input int c, input int t, input int w);
    return (c >= win_from(t, w)) && (c < t);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = ADDR_W'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = ADDR_W'(a); we = 1'b0;
    #1;
    v = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic restart();
    wr(A_CTRL, 32'h0);
    idle(1);
    wr(A_CTRL, 32'h8000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int t, w, d, c;
    void'($urandom(32'd7));
    rst_n = 1'b0; por_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1; por_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_STAT, v);  chk("R1 status", v, 0);
    rd(A_CNT, v);   chk("R1 count", v, 0);
    rd(A_TERM, v);  chk("R1 term", v, T0);
    rd(A_WIN, v);   chk("R1 win", v, W0);
    rd(A_CAUSE, v); chk("R1 cause", v, 0);
    chk("R1 rst_req", rst_req, 0);

    // R12 keys while disabled
    wr(A_PRE, 32'h4100);
    wr(A_CLR, 32'h09);
    rd(A_STAT, v); chk("R12 status", v, 0);
    chk("R12 rst_req", rst_req, 0);
    rd(A_CNT, v);  chk("R12 count", v, 0);

    // R2 set alias, R3 counting
    wr(A_CSET, 32'h8000);
    rd(A_CTRL, v); chk("R2 set alias", v, 32'h8000);
    idle(5);
    rd(A_CNT, v);  chk("R3 count 5", v, 5);
    wr(A_CCLR, 32'h8000);
    // R9 dead cycle
    rd(A_TERM, v); chk("R9 quiet read", v, 0);
    wr(A_TERM, 32'h55);
    rd(A_TERM, v); chk("R9 write ignored", v, T0);
    rd(A_CTRL, v); chk("R2 clear alias", v, 0);
    rd(A_CNT, v);  chk("R3 hold after stop", v, 6);
    idle(3);
    rd(A_CNT, v);  chk("R3 hold disabled", v, 6);
    wr(A_CTRL, 32'h8000);
    rd(A_CTRL, v); chk("R2 direct write", v, 32'h8000);
    rd(A_CNT, v);  chk("R3 restart zero", v, 0);
    wr(A_CTRL, 32'h0);
    idle(1);

    // R4 window, R8 timeout
    wr(A_TERM, 20);
    wr(A_WIN, 5);
    wr(A_CTRL, 32'h8000);
    idle(14);
    rd(A_STAT, v); chk("R4 before window", v, 0);
    idle(1);
    rd(A_STAT, v); chk("R4 window first", v, 1);
    idle(4);
    rd(A_STAT, v); chk("R4 window last", v, 1);
    idle(1);
    rd(A_STAT, v); chk("R4 closed at term", v, 0);
    chk("R8 no request yet", rst_req, 0);
    idle(1);
    rd(A_STAT, v); chk("R8 event", v, 32'h20);
    chk("R8 rst_req", rst_req, 1);
    idle(2);
    rd(A_CNT, v);  chk("R8 count holds", v, 20);

    // R10 reset cause
    rd(A_CAUSE, v); chk("R10 cause set", v, 32'h20);
    rst_n = 1'b0; idle(1); rst_n = 1'b1;
    rd(A_CAUSE, v); chk("R10 survives rst_n", v, 32'h20);
    chk("R1 rst_req after reset", rst_req, 0);
    wr(A_CAUSE, 32'h20);
    rd(A_CAUSE, v); chk("R10 w1c", v, 0);

    // R6 bad arm key, R11 restart clears
    wr(A_CSET, 32'h8000);
    wr(A_PRE, 32'h4100);
    rd(A_STAT, v); chk("R6 bad arm", v, 32'hA0);
    chk("R6 rst_req", rst_req, 1);
    restart();
    rd(A_STAT, v); chk("R11 flags cleared", v, 0);
    chk("R11 rst_req", rst_req, 0);

    // R7 outside window (start = 32)
    wr(A_PRE, 32'h4000);
    wr(A_CLR, 32'h08);
    rd(A_STAT, v); chk("R7 outside window", v, 32'h60);
    restart();
    idle(33);
    wr(A_CLR, 32'h08);
    rd(A_STAT, v); chk("R7 not armed", v, 32'h60);
    restart();
    idle(32);
    wr(A_PRE, 32'h4000);
    wr(A_CLR, 32'h07);
    rd(A_STAT, v); chk("R7 wrong clear", v, 32'h60);
    chk("R7 rst_req", rst_req, 1);

    // R5 valid services twice
    restart();
    for (int k = 0; k < 2; k++) begin
      idle(32);
      wr(A_PRE, 32'h4000);
      wr(A_CLR, 32'h08);
      rd(A_CNT, v);  chk("R5 count zero", v, 0);
      rd(A_STAT, v); chk("R5 no flags", v, 0);
    end

    // random service timing against bench-computed windows
    for (int i = 0; i < 40; i++) begin
      t = 10 + int'($urandom % 41);
      w = 1 + int'($urandom % (t + 4));
      d = int'($urandom % (t + 4));
      wr(A_CTRL, 32'h0);
      idle(1);
      wr(A_TERM, t);
      wr(A_WIN, w);
      wr(A_CTRL, 32'h8000);
      idle(d);
      rd(A_CNT, v); chk("R3 random count", v, (d < t) ? d : t);
      wr(A_PRE, 32'h4000);
      c = d + 1;
      wr(A_CLR, 32'h08);
      if (svc_expected(c, t, w)) begin
        rd(A_CNT, v);  chk("R5 random service count", v, 0);
        rd(A_STAT, v); chk("R5 random service flags", {29'd0, v[7:5]}, 0);
      end else begin
        rd(A_STAT, v); chk("R7 random reject flags", {29'd0, v[7:5]}, 3);
        chk("R7 random rst_req", rst_req, 1);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule